// File: doc/BRIEF.md
# Round-Robin Core Scheduler with Interrupt Core

This block decides which processor core runs the next instruction bundle. It manages eight general cores and one extra core that only runs interrupt handlers. Each general core has an instruction pointer and a run/paused flag. A command port lets the surrounding machine clear a core, load its instruction pointer, pause it, resume it, lock scheduling onto a single core (solo mode), program the handler address for each interrupt number, raise interrupts, and turn interrupt handling on or off.

The selected core index and its current instruction pointer are presented as long as that core owns the datapath. The datapath reports the end of each bundle with `step_done`, together with the instruction pointer the core should resume from. The end of an interrupt handler is reported with `irq_ret`. The scheduler only re-selects on those boundaries. A pending interrupt always wins at the next boundary. While its handler runs, the interrupt core is the only one selected and no other interrupt is accepted. Solo mode pins the selection to one general core but still lets interrupts through.

Top module: `core_sched`

## Requirements
- R1: After synchronous reset `idle` is 1 and `sel_valid` is 0. All general cores are paused with instruction pointer 0, interrupt handling is off, no interrupt is pending and every handler address is 0.
- R2: The general cores are served in ascending index order with wrap-around. The first core served after reset is the lowest active index. A core keeps the selection until `step_done`. The next pick is made at that edge and starts from the index after the last general core served.
- R3: Paused cores are skipped. Pause and resume change the selection only at the next boundary.
- R4: When handling is enabled and an interrupt is pending, the next boundary selects core index 8 (`irq_active` = 1) with `sel_ip` equal to that interrupt's handler address. Until `irq_ret`, the selection stays on core 8, `step_done` only advances `sel_ip`, and no further interrupt is taken.
- R5: Interrupts raised by command or by `irq_raise` are latched as pending while handling is off or a handler runs. When several are pending, the lowest number is taken first.
- R6: On `irq_ret`, the next pick is either another pending interrupt or the general core after the last general core served before the handler.
- R7: Solo mode (command 5) loads the named core's pointer from `cmd_addr`, makes the core active and selects only that core at every boundary until command 6 ends solo mode. Interrupts still preempt it.
- R8: Command 1 sets the named core's pointer to 0 and pauses the core. In the following cycle `clr_stb` is 1 for one cycle, with `clr_core` equal to that core.
- R9: With no active general core, no solo lock and no interrupt that can be taken, the scheduler asserts `idle`, deasserts `sel_valid` and drives `sel_ip` as 0. It re-evaluates every cycle.
- R10: `cmd_op` codes are: 0 none, 1 clear, 2 load pointer, 3 pause, 4 resume, 5 solo start, 6 solo end, 7 set handler address, 8 raise interrupt, 9 handling on, 10 handling off. Core commands that name an index of 8 or above have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Command code |
| cmd_core | input | 4 | Target general core |
| cmd_irq | input | 5 | Target interrupt number |
| cmd_addr | input | 16 | Pointer or handler address |
| step_done | input | 1 | Selected core finished a bundle |
| step_ip | input | 16 | Resume pointer of the finished core |
| irq_ret | input | 1 | Interrupt handler finished |
| irq_raise | input | 17 | Interrupt request lines, one per number |
| sel_valid | output | 1 | A core is selected |
| sel_core | output | 4 | Selected core, 8 is the interrupt core |
| sel_ip | output | 16 | Pointer of the selected core |
| irq_active | output | 1 | Interrupt handler running |
| idle | output | 1 | No core selected |
| clr_stb | output | 1 | Clear request for a core's registers and stacks |
| clr_core | output | 4 | Core to clear |

## Verification
The rotation is exercised with one active core, then with two active cores that must alternate and wrap past index 7. It is exercised again after a pause, so that a skipped core shows up as a repeated grant. Interrupts are raised in three situations: while handling is off, two at once in inverted order, and while a handler already runs. These cases separate latching, lowest-first priority and masking. They also show whether the rotation resumes from the last served core rather than from zero. Solo mode is run with a second core active and with an interrupt arriving, to show that switching stops but preemption does not. The sequence ends with a clear, a full pause into idle, an out-of-range command, and an interrupt taken from the idle state.

// File: rtl/sched_pkg.sv
package sched_pkg;

    typedef enum logic [3:0] {
        CMD_NONE     = 4'd0,
        CMD_CLEAR    = 4'd1,
        CMD_LOAD_IP  = 4'd2,
        CMD_PAUSE    = 4'd3,
        CMD_RESUME   = 4'd4,
        CMD_SOLO_ON  = 4'd5,
        CMD_SOLO_OFF = 4'd6,
        CMD_SET_VEC  = 4'd7,
        CMD_RAISE    = 4'd8,
        CMD_IRQ_ON   = 4'd9,
        CMD_IRQ_OFF  = 4'd10
    } sched_cmd_e;

    function automatic sched_cmd_e to_cmd(input logic [3:0] raw);
        return sched_cmd_e'(raw);
    endfunction

endpackage

// File: rtl/sched_rr_pick.sv
module sched_rr_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 1; k <= N; k++) begin
            int c;
            c = (int'(last) + k) % N;
            if (!found && req[c]) begin
                found = 1'b1;
                idx   = IW'(c);
            end
        end
    end
endmodule

// File: rtl/sched_lowest_pick.sv
module sched_lowest_pick #(
    parameter int N  = 17,
    parameter int IW = 5
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |req;
        idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) idx = IW'(k);
        end
    end
endmodule

// File: rtl/sched_core_slot.sv
module sched_core_slot
    import sched_pkg::*;
#(
    parameter int IP_W   = 16,
    parameter int CORE_W = 4,
    parameter int SLOT   = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  sched_cmd_e        cmd_op,
    input  logic [CORE_W-1:0] cmd_core,
    input  logic [IP_W-1:0]   cmd_addr,
    input  logic              wb_en,
    input  logic [IP_W-1:0]   wb_ip,
    output logic              active,
    output logic [IP_W-1:0]   ip
);
    logic hit;
    assign hit = cmd_valid && (cmd_core == CORE_W'(SLOT));

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            ip     <= '0;
        end else begin
            if (wb_en) ip <= wb_ip;
            if (hit) begin
                case (cmd_op)
                    CMD_CLEAR: begin
                        active <= 1'b0;
                        ip     <= '0;
                    end
                    CMD_LOAD_IP: ip <= cmd_addr;
                    CMD_PAUSE:   active <= 1'b0;
                    CMD_RESUME:  active <= 1'b1;
                    CMD_SOLO_ON: begin
                        active <= 1'b1;
                        ip     <= cmd_addr;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/core_sched.sv
module core_sched
    import sched_pkg::*;
#(
    parameter int NUM_GEN = 8,
    parameter int NUM_IRQ = 17,
    parameter int IP_W    = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cmd_valid,
    input  logic [3:0]                    cmd_op,
    input  logic [$clog2(NUM_GEN+1)-1:0]  cmd_core,
    input  logic [$clog2(NUM_IRQ)-1:0]    cmd_irq,
    input  logic [IP_W-1:0]               cmd_addr,
    input  logic                          step_done,
    input  logic [IP_W-1:0]               step_ip,
    input  logic                          irq_ret,
    input  logic [NUM_IRQ-1:0]            irq_raise,
    output logic                          sel_valid,
    output logic [$clog2(NUM_GEN+1)-1:0]  sel_core,
    output logic [IP_W-1:0]               sel_ip,
    output logic                          irq_active,
    output logic                          idle,
    output logic                          clr_stb,
    output logic [$clog2(NUM_GEN+1)-1:0]  clr_core
);
    localparam int CORE_W = $clog2(NUM_GEN + 1);
    localparam int GEN_W  = $clog2(NUM_GEN);
    localparam int IRQ_W  = $clog2(NUM_IRQ);
    localparam logic [CORE_W-1:0] IRQ_CORE = CORE_W'(NUM_GEN);

    typedef struct packed {
        logic              valid;
        logic              irq;
        logic [CORE_W-1:0] core;
    } grant_t;

    sched_cmd_e op;
    assign op = to_cmd(cmd_op);

    logic core_ok, irq_ok;
    assign core_ok = cmd_valid && (cmd_core < CORE_W'(NUM_GEN));
    assign irq_ok  = cmd_valid && (cmd_irq < IRQ_W'(NUM_IRQ));

    // State
    grant_t                     cur_q;
    logic                       in_irq_q;
    logic                       ien_q;
    logic                       solo_q;
    logic [GEN_W-1:0]           solo_core_q;
    logic [GEN_W-1:0]           last_q;
    logic [NUM_IRQ-1:0]         pend_q;
    logic [IP_W-1:0]            irq_ip_q;
    logic [IP_W-1:0]            vec_q [NUM_IRQ];

    // Per-core slots
    logic [NUM_GEN-1:0]           act;
    logic [NUM_GEN-1:0][IP_W-1:0] gip;

    generate
        for (genvar g = 0; g < NUM_GEN; g++) begin : g_slot
            logic wb;
            assign wb = step_done && cur_q.valid && !in_irq_q &&
                        (cur_q.core == CORE_W'(g));
            sched_core_slot #(
                .IP_W(IP_W), .CORE_W(CORE_W), .SLOT(g)
            ) i_slot (
                .clk(clk), .rst(rst),
                .cmd_valid(cmd_valid), .cmd_op(op),
                .cmd_core(cmd_core), .cmd_addr(cmd_addr),
                .wb_en(wb), .wb_ip(step_ip),
                .active(act[g]), .ip(gip[g])
            );
        end
    endgenerate

    // Candidate selection
    logic             rr_found;
    logic [GEN_W-1:0] rr_idx;
    logic             pd_found;
    logic [IRQ_W-1:0] pd_idx;

    sched_rr_pick #(.N(NUM_GEN), .IW(GEN_W)) i_rr (
        .req(act), .last(last_q), .found(rr_found), .idx(rr_idx)
    );

    sched_lowest_pick #(.N(NUM_IRQ), .IW(IRQ_W)) i_low (
        .req(pend_q), .found(pd_found), .idx(pd_idx)
    );

    logic   adv;
    grant_t nx;

    assign adv = !cur_q.valid || (step_done && !in_irq_q) || (irq_ret && in_irq_q);

    always_comb begin
        nx = '0;
        if (ien_q && pd_found) begin
            nx.valid = 1'b1;
            nx.irq   = 1'b1;
            nx.core  = IRQ_CORE;
        end else if (solo_q) begin
            nx.valid = 1'b1;
            nx.core  = CORE_W'(solo_core_q);
        end else if (rr_found) begin
            nx.valid = 1'b1;
            nx.core  = CORE_W'(rr_idx);
        end
    end

    logic [NUM_IRQ-1:0] pend_n;
    always_comb begin
        pend_n = pend_q;
        if (adv && nx.irq) pend_n[pd_idx] = 1'b0;
        pend_n = pend_n | irq_raise;
        if (irq_ok && op == CMD_RAISE) pend_n[cmd_irq] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q       <= '0;
            in_irq_q    <= 1'b0;
            ien_q       <= 1'b0;
            solo_q      <= 1'b0;
            solo_core_q <= '0;
            last_q      <= GEN_W'(NUM_GEN - 1);
            pend_q      <= '0;
            irq_ip_q    <= '0;
            clr_stb     <= 1'b0;
            clr_core    <= '0;
            for (int i = 0; i < NUM_IRQ; i++) vec_q[i] <= '0;
        end else begin
            pend_q  <= pend_n;
            clr_stb <= core_ok && op == CMD_CLEAR;
            if (core_ok && op == CMD_CLEAR) clr_core <= cmd_core;

            if (step_done && in_irq_q) irq_ip_q <= step_ip;
            if (adv) begin
                cur_q    <= nx;
                in_irq_q <= nx.irq;
                if (nx.irq) irq_ip_q <= vec_q[pd_idx];
                if (nx.valid && !nx.irq) last_q <= nx.core[GEN_W-1:0];
            end

            if (cmd_valid) begin
                case (op)
                    CMD_IRQ_ON:  ien_q <= 1'b1;
                    CMD_IRQ_OFF: ien_q <= 1'b0;
                    CMD_SOLO_OFF: solo_q <= 1'b0;
                    CMD_SOLO_ON: if (core_ok) begin
                        solo_q      <= 1'b1;
                        solo_core_q <= cmd_core[GEN_W-1:0];
                    end
                    CMD_SET_VEC: if (irq_ok) vec_q[cmd_irq] <= cmd_addr;
                    default: ;
                endcase
            end
        end
    end

    assign sel_valid  = cur_q.valid;
    assign sel_core   = cur_q.core;
    assign irq_active = in_irq_q;
    assign idle       = !cur_q.valid;
    assign sel_ip     = !cur_q.valid ? '0 :
                        in_irq_q     ? irq_ip_q : gip[cur_q.core[GEN_W-1:0]];

endmodule

// File: rtl/core_sched_chk.sv
module core_sched_chk #(
    parameter int NUM_GEN = 8,
    parameter int CORE_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [3:0]        cmd_op,
    input logic [CORE_W-1:0] cmd_core,
    input logic              step_done,
    input logic              irq_ret,
    input logic              sel_valid,
    input logic [CORE_W-1:0] sel_core,
    input logic              irq_active,
    input logic              clr_stb
);
    localparam logic [CORE_W-1:0] IRQ_CORE = CORE_W'(NUM_GEN);

    a_r4_irq_core: assert property (@(posedge clk) disable iff (rst)
        irq_active |-> (sel_valid && sel_core == IRQ_CORE));

    a_r4_handler_holds: assert property (@(posedge clk) disable iff (rst)
        (irq_active && !irq_ret) |=> irq_active);

    a_r2_hold_until_done: assert property (@(posedge clk) disable iff (rst)
        (sel_valid && !step_done && !irq_ret) |=> (sel_valid && $stable(sel_core)));

    a_r3_general_range: assert property (@(posedge clk) disable iff (rst)
        (sel_valid && !irq_active) |-> (sel_core < IRQ_CORE));

    a_r8_clear_cause: assert property (@(posedge clk) disable iff (rst)
        clr_stb |-> $past(cmd_valid && cmd_op == 4'd1 && cmd_core < IRQ_CORE));
endmodule

bind core_sched core_sched_chk #(
    .NUM_GEN(NUM_GEN), .CORE_W($clog2(NUM_GEN + 1))
) i_core_sched_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_core(cmd_core), .step_done(step_done), .irq_ret(irq_ret),
    .sel_valid(sel_valid), .sel_core(sel_core), .irq_active(irq_active),
    .clr_stb(clr_stb)
);

// File: tb/test_core_sched.sv
module test_core_sched;
    import sched_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = '0;
    logic [3:0]  cmd_core = '0;
    logic [4:0]  cmd_irq = '0;
    logic [15:0] cmd_addr = '0;
    logic        step_done = 1'b0;
    logic [15:0] step_ip = '0;
    logic        irq_ret = 1'b0;
    logic [16:0] irq_raise = '0;
    logic        sel_valid, irq_active, idle, clr_stb;
    logic [3:0]  sel_core, clr_core;
    logic [15:0] sel_ip;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    core_sched i_core_sched (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_core(cmd_core), .cmd_irq(cmd_irq), .cmd_addr(cmd_addr),
        .step_done(step_done), .step_ip(step_ip), .irq_ret(irq_ret),
        .irq_raise(irq_raise), .sel_valid(sel_valid), .sel_core(sel_core),
        .sel_ip(sel_ip), .irq_active(irq_active), .idle(idle),
        .clr_stb(clr_stb), .clr_core(clr_core)
    );

    typedef struct {
        bit    valid;
        int    core;
        int    ip;
        string tag;
    } exp_t;

    exp_t sb[$];

    // Driver side
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic cmd(sched_cmd_e o, int core, int irq, int addr);
        cmd_valid = 1'b1;
        cmd_op    = 4'(o);
        cmd_core  = 4'(core);
        cmd_irq   = 5'(irq);
        cmd_addr  = 16'(addr);
        tick();
        cmd_valid = 1'b0;
    endtask

    task automatic step(int nip);
        step_done = 1'b1;
        step_ip   = 16'(nip);
        tick();
        step_done = 1'b0;
    endtask

    task automatic ret();
        irq_ret = 1'b1;
        tick();
        irq_ret = 1'b0;
    endtask

    task automatic expect_sel(bit v, int core, int ip, string tag);
        exp_t e;
        e.valid = v; e.core = core; e.ip = ip; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic chk(int act, int exp, string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor side: compares queued expectations away from the edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (!e.valid) begin
                if (sel_valid !== 1'b0 || idle !== 1'b1 || sel_ip !== 16'd0) begin
                    errors++;
                    $display("FAIL %s actual valid=%0b idle=%0b ip=%0d expected idle",
                             e.tag, sel_valid, idle, sel_ip);
                end
            end else if (sel_valid !== 1'b1 || int'(sel_core) != e.core ||
                         int'(sel_ip) != e.ip) begin
                errors++;
                $display("FAIL %s actual core=%0d ip=%0d valid=%0b expected core=%0d ip=%0d",
                         e.tag, sel_core, sel_ip, sel_valid, e.core, e.ip);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        expect_sel(0, 0, 0, "R1 reset idle");
        chk(int'(irq_active), 0, "R1 no handler");
        chk(int'(clr_stb), 0, "R1 no clear");

        // R2 single core
        cmd(CMD_LOAD_IP, 3, 0, 100);
        cmd(CMD_RESUME, 3, 0, 0);
        expect_sel(0, 0, 0, "R3 resume waits a cycle");
        tick();
        expect_sel(1, 3, 100, "R2 first grant core3");

        // R2 two cores with wrap
        cmd(CMD_LOAD_IP, 5, 0, 200);
        cmd(CMD_RESUME, 5, 0, 0);
        expect_sel(1, 3, 100, "R3 resume no mid-bundle switch");
        step(101);
        expect_sel(1, 5, 200, "R2 rotate to core5");
        step(201);
        expect_sel(1, 3, 101, "R2 wrap to core3");

        // R3 pause skips
        cmd(CMD_PAUSE, 5, 0, 0);
        step(102);
        expect_sel(1, 3, 102, "R3 paused core5 skipped");

        // R5 latch while disabled, lowest first
        cmd(CMD_SET_VEC, 0, 4, 500);
        cmd(CMD_SET_VEC, 0, 2, 600);
        cmd(CMD_RAISE, 0, 4, 0);
        step(103);
        expect_sel(1, 3, 103, "R5 disabled irq not taken");
        cmd(CMD_RAISE, 0, 2, 0);
        cmd(CMD_IRQ_ON, 0, 0, 0);
        step(104);
        expect_sel(1, 8, 600, "R5 lowest pending first");
        chk(int'(irq_active), 1, "R4 handler active");
        step(601);
        expect_sel(1, 8, 601, "R4 only interrupt core runs");
        cmd(CMD_RESUME, 5, 0, 0);
        expect_sel(1, 8, 601, "R4 resume ignored during handler");
        ret();
        expect_sel(1, 8, 500, "R5 next pending after return");
        ret();
        expect_sel(1, 5, 201, "R6 rotation resumes after core3");
        chk(int'(irq_active), 0, "R6 handler left");
        step(202);
        expect_sel(1, 3, 104, "R2 wrap after handler");

        // R7 solo
        step(105);
        expect_sel(1, 5, 202, "R2 core5 again");
        cmd(CMD_SOLO_ON, 3, 0, 300);
        step(203);
        expect_sel(1, 3, 300, "R7 solo core3 at new pointer");
        step(301);
        expect_sel(1, 3, 301, "R7 solo blocks switching");
        cmd(CMD_SET_VEC, 0, 1, 700);
        cmd(CMD_RAISE, 0, 1, 0);
        step(302);
        expect_sel(1, 8, 700, "R7 interrupt preempts solo");
        ret();
        expect_sel(1, 3, 302, "R7 solo resumes after handler");
        cmd(CMD_SOLO_OFF, 0, 0, 0);
        step(303);
        expect_sel(1, 5, 203, "R7 solo end restores rotation");

        // R5 raise line while disabled
        cmd(CMD_IRQ_OFF, 0, 0, 0);
        irq_raise = 17'h00040;
        tick();
        irq_raise = '0;
        step(204);
        expect_sel(1, 3, 303, "R5 raised line held pending");

        // R8 clear
        step(304);
        expect_sel(1, 5, 204, "R2 core5");
        cmd(CMD_CLEAR, 3, 0, 0);
        chk(int'(clr_stb), 1, "R8 clear strobe");
        chk(int'(clr_core), 3, "R8 clear core");
        expect_sel(1, 5, 204, "R8 clear leaves running core");
        tick();
        chk(int'(clr_stb), 0, "R8 strobe one cycle");
        step(205);
        expect_sel(1, 5, 205, "R8 cleared core paused");
        cmd(CMD_RESUME, 3, 0, 0);
        step(206);
        expect_sel(1, 3, 0, "R8 cleared pointer zero");

        // R9 idle
        cmd(CMD_PAUSE, 3, 0, 0);
        cmd(CMD_PAUSE, 5, 0, 0);
        step(1);
        expect_sel(0, 0, 0, "R9 idle all paused");

        // R10 out-of-range core ignored
        cmd(CMD_RESUME, 9, 0, 0);
        tick();
        expect_sel(0, 0, 0, "R10 core 9 command ignored");
        cmd(CMD_SOLO_ON, 8, 0, 50);
        tick();
        expect_sel(0, 0, 0, "R10 solo on core 8 ignored");

        // R9 interrupt taken from idle
        cmd(CMD_SET_VEC, 0, 6, 800);
        cmd(CMD_IRQ_ON, 0, 0, 0);
        expect_sel(0, 0, 0, "R9 still idle at enable edge");
        tick();
        expect_sel(1, 8, 800, "R9 idle takes pending irq");
        ret();
        expect_sel(0, 0, 0, "R9 idle after handler");

        tick();
        tick();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule